// File: doc/BRIEF.md
# Condition Flag Register and Branch Condition Tester

This block holds the processor's five arithmetic flags (extend, negative, zero, overflow, carry) together with a privilege bit. The flags and the privilege bit are packed into a 16-bit status word. The low byte of that word is the condition byte.

A 4-bit condition selector is decoded combinationally against the stored flags. The result is a single true/false output that a branch or loop unit can use directly.

The flags change in two ways:
- The ALU presents new flag values with a strobe.
- A logical immediate (AND, OR, XOR, or a plain load) is applied either to the condition byte or to the whole status word.

The condition byte may be changed at any privilege level. Changes aimed at the whole status word take effect only while the privilege bit is set. Once software clears the privilege bit, only a reset restores it.

Top module: `flag_status_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the status word reads 0x2000: privilege bit set and all five flags clear.
- R2: Status word layout: carry in bit 0, overflow in bit 1, zero in bit 2, negative in bit 3, extend in bit 4, privilege in bit 13. All other bits read zero. `cond_byte` always equals bits 7:0 of the status word.
- R3: When `alu_we` is high and `imm_valid` is low, the status word bits 4:0 hold `alu_flags` after the next clock edge, and the privilege bit is unchanged.
- R4: Selector codes 0 to 3 give, in order: true; false; carry and zero both clear; carry or zero set.
- R5: Selector codes 4 to 11 give, in order: carry clear, carry set, zero clear, zero set, overflow clear, overflow set, negative clear, negative set.
- R6: Selector codes 12 to 15 give, in order: negative equals overflow; negative differs from overflow; negative equals overflow and zero clear; negative differs from overflow or zero set.
- R7: With `imm_valid` high and `imm_to_sr` low, the flags become the operation's result on bits 4:0 of the current word and `imm_data`. This happens at any privilege level. The operation is `imm_op` 0=AND, 1=OR, 2=XOR, 3=load. The privilege bit does not change.
- R8: With `imm_valid` and `imm_to_sr` high while the privilege bit is set, the flags and the privilege bit take the operation's result on bits 4:0 and bit 13 of the current word and `imm_data`.
- R9: With `imm_valid` and `imm_to_sr` high while the privilege bit is clear, the status word does not change. The load operation is included. The privilege bit can never be set again except by reset.
- R10: When `imm_valid` is high, `alu_we` is ignored in that cycle. This holds even if the immediate request itself is rejected under R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cond_sel | input | 4 | Branch condition selector |
| cond_true | output | 1 | Condition result for `cond_sel` against the current flags |
| alu_we | input | 1 | ALU flag update strobe |
| alu_flags | input | 5 | New flags {X,N,Z,V,C} |
| imm_valid | input | 1 | Logical immediate request |
| imm_op | input | 2 | 0 AND, 1 OR, 2 XOR, 3 load |
| imm_to_sr | input | 1 | 0 targets the condition byte, 1 the whole status word |
| imm_data | input | 16 | Immediate operand |
| status_word | output | 16 | Full status word |
| cond_byte | output | 8 | Low byte of the status word |

## Verification
The ALU flag strobe and a logical immediate request can land in the same cycle. The bench raises both together, both on purpose and at random. It then checks that only the immediate result reaches the flags. It also covers the case where the immediate is a rejected status-word request made without privilege: there the flags must keep their old value rather than take the ALU's. The bench also drops privilege mid-run to confirm that status-word requests stay inert while byte requests still work.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  localparam int FLAG_W  = 5;
  localparam int WORD_W  = 16;
  localparam int SUP_POS = 13;
  localparam int SEL_W   = 4;

  typedef enum logic [1:0] {
    OP_AND  = 2'd0,
    OP_OR   = 2'd1,
    OP_XOR  = 2'd2,
    OP_LOAD = 2'd3
  } imm_op_e;

  function automatic logic [WORD_W-1:0] apply_op(imm_op_e op,
                                                 logic [WORD_W-1:0] cur,
                                                 logic [WORD_W-1:0] opnd);
    logic [WORD_W-1:0] r;
    unique case (op)
      OP_AND:  r = cur & opnd;
      OP_OR:   r = cur | opnd;
      OP_XOR:  r = cur ^ opnd;
      default: r = opnd;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fsu_rst_sync.sv
module fsu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fsu_cond_eval.sv
module fsu_cond_eval
  import fsu_pkg::*;
(
  input  logic [SEL_W-1:0]  code,
  input  logic [FLAG_W-1:0] flags,
  output logic              hit
);
  logic c, v, z, n, base;

  assign c = flags[0];
  assign v = flags[1];
  assign z = flags[2];
  assign n = flags[3];

  // Even codes carry the base test; odd codes are its complement.
  always_comb begin
    unique case (code[SEL_W-1:1])
      3'd0:    base = 1'b1;
      3'd1:    base = ~c & ~z;
      3'd2:    base = ~c;
      3'd3:    base = ~z;
      3'd4:    base = ~v;
      3'd5:    base = ~n;
      3'd6:    base = ~(n ^ v);
      default: base = ~(n ^ v) & ~z;
    endcase
  end

  assign hit = base ^ code[0];
endmodule

// File: rtl/fsu_next.sv
module fsu_next
  import fsu_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_q,
  input  logic              sup_q,
  input  logic              alu_we,
  input  logic [FLAG_W-1:0] alu_flags,
  input  logic              imm_valid,
  input  imm_op_e           imm_op,
  input  logic              imm_to_sr,
  input  logic [WORD_W-1:0] imm_data,
  output logic [FLAG_W-1:0] flags_d,
  output logic              flags_en,
  output logic              sup_d,
  output logic              sup_en
);
  logic [WORD_W-1:0] cur_word;
  logic [WORD_W-1:0] op_res;

  always_comb begin
    cur_word          = '0;
    cur_word[FLAG_W-1:0] = flags_q;
    cur_word[SUP_POS] = sup_q;
  end

  assign op_res = apply_op(imm_op, cur_word, imm_data);

  always_comb begin
    flags_d  = flags_q;
    flags_en = 1'b0;
    sup_d    = sup_q;
    sup_en   = 1'b0;
    if (imm_valid) begin
      if (!imm_to_sr) begin
        flags_d  = op_res[FLAG_W-1:0];
        flags_en = 1'b1;
      end else if (sup_q) begin
        flags_d  = op_res[FLAG_W-1:0];
        flags_en = 1'b1;
        sup_d    = op_res[SUP_POS];
        sup_en   = 1'b1;
      end
    end else if (alu_we) begin
      flags_d  = alu_flags;
      flags_en = 1'b1;
    end
  end
endmodule

// File: rtl/flag_status_unit.sv
module flag_status_unit
  import fsu_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  cond_sel,
  output logic              cond_true,
  input  logic              alu_we,
  input  logic [FLAG_W-1:0] alu_flags,
  input  logic              imm_valid,
  input  logic [1:0]        imm_op,
  input  logic              imm_to_sr,
  input  logic [WORD_W-1:0] imm_data,
  output logic [WORD_W-1:0] status_word,
  output logic [7:0]        cond_byte
);
  logic              rst_n_int;
  logic [FLAG_W-1:0] flags_q, flags_d;
  logic              flags_en;
  logic              sup_q, sup_d, sup_en;

  fsu_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  fsu_next u_next (
    .flags_q   (flags_q),
    .sup_q     (sup_q),
    .alu_we    (alu_we),
    .alu_flags (alu_flags),
    .imm_valid (imm_valid),
    .imm_op    (imm_op_e'(imm_op)),
    .imm_to_sr (imm_to_sr),
    .imm_data  (imm_data),
    .flags_d   (flags_d),
    .flags_en  (flags_en),
    .sup_d     (sup_d),
    .sup_en    (sup_en)
  );

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)    flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  sup_q <= 1'b1;
    else if (sup_en) sup_q <= sup_d;
  end

  fsu_cond_eval u_cond (
    .code  (cond_sel),
    .flags (flags_q),
    .hit   (cond_true)
  );

  always_comb begin
    status_word                = '0;
    status_word[FLAG_W-1:0]    = flags_q;
    status_word[SUP_POS]       = sup_q;
  end

  assign cond_byte = status_word[7:0];
endmodule

// File: rtl/fsu_chk.sv
module fsu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  cond_sel,
  input logic        cond_true,
  input logic        alu_we,
  input logic [4:0]  alu_flags,
  input logic        imm_valid,
  input logic        imm_to_sr,
  input logic [15:0] status_word
);
  // R2
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word & 16'hDFE0) == 16'h0000);

  // R3
  alu_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alu_we && !imm_valid |=> status_word[4:0] == $past(alu_flags));

  // R4
  always_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_sel == 4'd0 |-> cond_true);

  // R6
  greater_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_sel == 4'd14 && cond_true |-> !status_word[2] && (status_word[3] == status_word[1]));

  // R7
  byte_keeps_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imm_valid && !imm_to_sr |=> status_word[13] == $past(status_word[13]));

  // R9
  user_word_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imm_valid && imm_to_sr && !status_word[13] |=> $stable(status_word));

  // R9
  sup_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(status_word[13]));
endmodule

bind flag_status_unit fsu_chk u_chk (.*);

// File: tb/flag_status_unit_test.sv
module flag_status_unit_test;
  logic        clk;
  logic        rst_n;
  logic [3:0]  cond_sel;
  logic        cond_true;
  logic        alu_we;
  logic [4:0]  alu_flags;
  logic        imm_valid;
  logic [1:0]  imm_op;
  logic        imm_to_sr;
  logic [15:0] imm_data;
  logic [15:0] status_word;
  logic [7:0]  cond_byte;

  int total = 0;
  int bad   = 0;
  logic [15:0] model;
  string st_tag;

  flag_status_unit uut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit exp_cond(logic [3:0] code, logic [15:0] w);
    bit c = w[0], v = w[1], z = w[2], n = w[3];
    case (code)
      4'd0:  return 1;
      4'd1:  return 0;
      4'd2:  return !c && !z;
      4'd3:  return c || z;
      4'd4:  return !c;
      4'd5:  return c;
      4'd6:  return !z;
      4'd7:  return z;
      4'd8:  return !v;
      4'd9:  return v;
      4'd10: return !n;
      4'd11: return n;
      4'd12: return n == v;
      4'd13: return n != v;
      4'd14: return (n == v) && !z;
      default: return (n != v) || z;
    endcase
  endfunction

  function automatic logic [15:0] exp_next(logic [15:0] w, bit aw, logic [4:0] af,
                                           bit iv, logic [1:0] op, bit sr, logic [15:0] d);
    logic [15:0] r;
    logic [15:0] keep = 16'h201F;
    if (!iv) return aw ? {w[15:5], af} : w;
    if (sr && !w[13]) return w;
    case (op)
      2'd0: r = w & d;
      2'd1: r = w | d;
      2'd2: r = w ^ d;
      default: r = d;
    endcase
    r = r & keep;
    if (!sr) r = {w[15:5], r[4:0]};
    return r;
  endfunction

  function automatic string cond_tag(logic [3:0] code);
    if (code < 4) return "R4";
    if (code < 12) return "R5";
    return "R6";
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit aw, logic [4:0] af, bit iv, logic [1:0] op, bit sr,
                      logic [15:0] d, logic [3:0] code);
    @(negedge clk);
    alu_we = aw; alu_flags = af; imm_valid = iv; imm_op = op; imm_to_sr = sr;
    imm_data = d; cond_sel = code;
    #1;
    check(st_tag, status_word, model);
    check("R2", {8'h00, cond_byte}, {8'h00, model[7:0]});
    check(cond_tag(code), {15'd0, cond_true}, {15'd0, exp_cond(code, model)});
    if (iv && aw) st_tag = "R10";
    else if (iv && sr) st_tag = model[13] ? "R8" : "R9";
    else if (iv) st_tag = "R7";
    else st_tag = "R3";
    model = exp_next(model, aw, af, iv, op, sr, d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    alu_we = 0; imm_valid = 0; alu_flags = '0; imm_op = '0; imm_to_sr = 0;
    imm_data = '0; cond_sel = '0;
    #1;
    check("R1", status_word, 16'h2000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model = 16'h2000;
    st_tag = "R1";
  endtask

  task automatic random_run(int n, int sup_bias);
    for (int i = 0; i < n; i++) begin
      logic [15:0] d = 16'($urandom);
      bit sr = ($urandom % 4) == 0;
      logic [1:0] op = 2'($urandom);
      if (sr && ($urandom % 100) < sup_bias) d[13] = (op == 2'd2) ? 1'b0 : 1'b1;
      step(($urandom % 3) == 0, 5'($urandom), ($urandom % 3) == 0, op, sr, d,
           4'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    do_reset();
    // directed: every condition code against a few flag patterns (R4 R5 R6)
    for (int p = 0; p < 32; p += 5) begin
      step(1, 5'(p), 0, 0, 0, 0, 0);
      for (int c = 0; c < 16; c++) step(0, 0, 0, 0, 0, 0, 4'(c));
    end
    // R8 word load keeps privilege, sets flags
    step(0, 0, 1, 2'd3, 1, 16'hFFFF, 4'd0);
    // R7 byte AND / OR / XOR
    step(0, 0, 1, 2'd0, 0, 16'h0015, 4'd2);
    step(0, 0, 1, 2'd1, 0, 16'h00E2, 4'd3);
    step(0, 0, 1, 2'd2, 0, 16'h001F, 4'd14);
    // R10 both in the same cycle, privileged
    step(1, 5'h1F, 1, 2'd3, 0, 16'h0000, 4'd15);
    // R8 drop privilege with word AND
    step(0, 0, 1, 2'd0, 1, 16'h001F, 4'd0);
    // R9 word OR/load ignored without privilege
    step(0, 0, 1, 2'd1, 1, 16'h201F, 4'd1);
    step(0, 0, 1, 2'd3, 1, 16'h2000, 4'd1);
    // R10 rejected word request blocks ALU strobe
    step(1, 5'h0A, 1, 2'd1, 1, 16'h2000, 4'd12);
    // R7 byte op still works in user mode
    step(0, 0, 1, 2'd1, 0, 16'h0004, 4'd7);
    step(1, 5'h09, 0, 0, 0, 0, 4'd13);
    random_run(1500, 90);
    do_reset();
    random_run(1500, 40);
    step(0, 0, 0, 0, 0, 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule